// File: doc/BRIEF.md
# Access Token Address-Space Resolver

This unit turns a 32-bit access token, which names an entry in an access list, into the 64-bit address-space control element that a later translation stage uses. Two token values and access register zero resolve at once from control-register inputs. Every other token starts a walk through guest memory, one doubleword read at a time. The walk reads a list designator, then a two-doubleword list entry, then the second-table entry that the list entry points to. When the list entry is private and its authorization index differs from the caller's, the walk also reads one byte of an authority table.

Each check along the walk either lets the walk go on or ends it with an exception code. The checks cover token format, list bounds, address overflow, validity bits, sequence numbers, authority and write permission. A caller pulses `start` with the register number, the token and a write flag. It waits for the one-cycle `done` strobe and then reads either a zero code with the element, or a nonzero code.

Top module: `aspace_token_xlate`

## Requirements
- R1: When `ar_num` is 0 or the token is zero, `done` rises one cycle after `start`. The element is `ctl_primary`, the code is 0x00 and no memory read is issued. Register zero wins over every token check.
- R2: A token of exactly 1 (with a nonzero `ar_num`) returns `ctl_secondary` with code 0x00 and issues no memory read.
- R3: Token bits 31:25 are reserved. If any of them is set and neither R1 nor R2 applies, the code is 0x28 and no read is issued. Bit 24 is the private flag, bits 23:16 the sequence number and bits 15:0 the entry number.
- R4: An `ar_num` of `NUM_AR` (16) or more gives code 0xFF with no memory read. This check takes precedence over R1 to R3.
- R5: The designator doubleword is read at (low 32 bits of `ctl_priv_base` when the private flag is set, else of `ctl_list_base`) AND 0x7FFFFFC0, plus 16. Its bits 62:39 hold the list origin and bits 38:32 the list length.
- R6: If the entry number divided by 8 exceeds the list length, the code is 0x29 and only the designator read is issued. Equality passes.
- R7: The list entry is read at origin*128 + entry*16. If that sum exceeds 0x7FFFFFFF, the code is 0x05 and no further read is issued. The first entry doubleword holds invalid (63), fetch-only (57), private (56), sequence (55:48) and authorization index (47:32). The second holds the table origin (62:38) and a 32-bit table sequence (31:0).
- R8: A set invalid bit in the list entry gives 0x29. A sequence number that differs from the token's gives 0x2A. In both cases the walk stops after the first entry doubleword.
- R9: The second-table entry is at table origin*64. A set bit 63 of its first doubleword gives 0x2B. A mismatch between bits 31:0 of the doubleword at +16 and the list entry's table sequence gives 0x2C. Bits 62:34 of the first doubleword hold the authority origin and bits 15:4 the authority length.
- R10: For a private list entry whose authorization index differs from bits 31:16 of `ctl_auth_idx`, an index/16 greater than the authority length gives 0x2D without a table read.
- R11: Otherwise the doubleword holding byte address authority-origin*4 + index/4 is read, with byte offset 0 at bits 63:56. Bit 0x40 >> ((index & 3)*2) of that byte must be set, else the code is 0x2D. A matching index skips the table read.
- R12: A fetch-only list entry used with `wr` set gives 0x04. Used for a read, the walk completes normally.
- R13: At most one read is outstanding, and every read address is 8-byte aligned. A response with `mem_rsp_err` set ends the walk with 0x05, with `done` one cycle later.
- R14: On success the element is the doubleword at second-table entry + 8 and the code is 0x00. On any nonzero code the element is zero. Both hold until the next `done`, and both are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a resolution (taken when idle) |
| ar_num | input | AR_IDX_W | Access register number |
| token | input | 32 | Access token |
| wr | input | 1 | Access is a store |
| ctl_primary | input | 64 | Primary control element |
| ctl_secondary | input | 64 | Secondary control element |
| ctl_list_base | input | 64 | Designator base for non-private tokens |
| ctl_priv_base | input | 64 | Designator base for private tokens |
| ctl_auth_idx | input | 64 | Extended authorization index in bits 31:16 |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | ADDR_W | Doubleword-aligned read address |
| mem_rsp_valid | input | 1 | Read response strobe |
| mem_rsp_err | input | 1 | Response is an addressing error |
| mem_rsp_data | input | 64 | Read data |
| done | output | 1 | Result strobe |
| elem | output | 64 | Resolved control element |
| exc_code | output | 8 | 0x00 or exception code |

## Verification
The assertions assume that memory answers each request exactly once, after at least one cycle, and never answers without a request. They also assume that `start` is raised only while the unit is idle. The bench's memory responder sees a request on a falling edge, waits one to three cycles and returns a single response strobe. The bench raises `start` only after the previous `done`. Tables are rebuilt for each vector, so each corrupted field reaches exactly one check of the walk.

// File: rtl/atx_pkg.sv
package atx_pkg;
  localparam int DW_W = 64;

  typedef logic [7:0] code_t;
  localparam code_t C_OK      = 8'h00;
  localparam code_t C_PROT    = 8'h04;
  localparam code_t C_ADDR    = 8'h05;
  localparam code_t C_TOKSPEC = 8'h28;
  localparam code_t C_ENTRY   = 8'h29;
  localparam code_t C_ENTSEQ  = 8'h2A;
  localparam code_t C_SECVAL  = 8'h2B;
  localparam code_t C_SECSEQ  = 8'h2C;
  localparam code_t C_AUTH    = 8'h2D;
  localparam code_t C_BADREG  = 8'hFF;

  typedef enum logic [2:0] {
    W_IDLE, W_DES, W_LE0, W_LE1, W_SE0, W_SE2, W_AUTH, W_SE1
  } walk_e;

  typedef struct packed {
    logic        primary;
    logic        secondary;
    logic        bad_reg;
    logic        rsv_bad;
    logic        priv;
    logic [7:0]  seq;
    logic [15:0] entry;
  } tok_info_t;
endpackage

// File: rtl/atx_token_split.sv
module atx_token_split #(
  parameter int NUM_AR   = 16,
  parameter int AR_IDX_W = 5
) (
  input  logic [AR_IDX_W-1:0] ar_num,
  input  logic [31:0]         token,
  output atx_pkg::tok_info_t  info
);
  always_comb begin
    info.bad_reg   = (int'(ar_num) >= NUM_AR);
    info.primary   = (ar_num == '0) || (token == 32'd0);
    info.secondary = (token == 32'd1);
    info.rsv_bad   = |token[31:25];
    info.priv      = token[24];
    info.seq       = token[23:16];
    info.entry     = token[15:0];
  end
endmodule

// File: rtl/atx_auth_pick.sv
module atx_auth_pick #(
  parameter int ADDR_W = 32
) (
  input  logic [15:0]       eax,
  input  logic [11:0]       atl,
  input  logic [28:0]       ato,
  input  logic [63:0]       rd_data,
  output logic              over_len,
  output logic [ADDR_W-1:0] dw_addr,
  output logic              granted
);
  logic [ADDR_W-1:0] byte_addr;
  logic [7:0]        sel_byte;
  logic [7:0]        mask;

  always_comb begin
    over_len  = eax[15:4] > atl;
    byte_addr = ADDR_W'({ato, 2'b00}) + ADDR_W'(eax[15:2]);
    dw_addr   = {byte_addr[ADDR_W-1:3], 3'b000};
    sel_byte  = 8'h00;
    for (int b = 0; b < 8; b++) begin
      if (byte_addr[2:0] == 3'(b)) sel_byte = rd_data[63-8*b -: 8];
    end
    mask    = 8'h40 >> {eax[1:0], 1'b0};
    granted = |(sel_byte & mask);
  end
endmodule

// File: rtl/aspace_token_xlate.sv
module aspace_token_xlate
  import atx_pkg::*;
#(
  parameter int NUM_AR   = 16,
  parameter int AR_IDX_W = $clog2(NUM_AR) + 1,
  parameter int ADDR_W   = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [AR_IDX_W-1:0] ar_num,
  input  logic [31:0]         token,
  input  logic                wr,
  input  logic [DW_W-1:0]     ctl_primary,
  input  logic [DW_W-1:0]     ctl_secondary,
  input  logic [DW_W-1:0]     ctl_list_base,
  input  logic [DW_W-1:0]     ctl_priv_base,
  input  logic [DW_W-1:0]     ctl_auth_idx,
  output logic                mem_req,
  output logic [ADDR_W-1:0]   mem_addr,
  input  logic                mem_rsp_valid,
  input  logic                mem_rsp_err,
  input  logic [DW_W-1:0]     mem_rsp_data,
  output logic                done,
  output logic [DW_W-1:0]     elem,
  output logic [7:0]          exc_code
);
  localparam logic [ADDR_W-1:0] DES_OFS = ADDR_W'(16);
  localparam logic [ADDR_W-1:0] DW_STEP = ADDR_W'(8);

  walk_e             st;
  tok_info_t         ti;
  logic [7:0]        seq_q;
  logic [15:0]       entry_q;
  logic              wr_q, fo_q, pv_q;
  logic [15:0]       eax_q, aix_q;
  logic [ADDR_W-1:0] le_addr_q, se_addr_q;
  logic [31:0]       se_sn_q;
  logic [28:0]       ato_q;
  logic [11:0]       atl_q;
  logic              req_q, done_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DW_W-1:0]   elem_q;
  code_t             code_q;

  logic              rd_go, fin;
  logic [ADDR_W-1:0] rd_addr;
  walk_e             rd_next;
  code_t             fin_code;
  logic [DW_W-1:0]   fin_elem;
  logic [32:0]       le_sum;
  logic [31:0]       des_raw;
  logic              over_len, granted;
  logic [ADDR_W-1:0] auth_dw;
  logic              unused_bits;

  assign unused_bits = ^{ctl_list_base[63:32], ctl_priv_base[63:32],
                         ctl_auth_idx[63:32], ctl_auth_idx[15:0]};

  atx_token_split #(.NUM_AR(NUM_AR), .AR_IDX_W(AR_IDX_W)) u_split (
    .ar_num(ar_num), .token(token), .info(ti)
  );

  atx_auth_pick #(.ADDR_W(ADDR_W)) u_auth (
    .eax(eax_q), .atl(atl_q), .ato(ato_q), .rd_data(mem_rsp_data),
    .over_len(over_len), .dw_addr(auth_dw), .granted(granted)
  );

  assign des_raw = (ti.priv ? ctl_priv_base[31:0] : ctl_list_base[31:0]) & 32'h7FFF_FFC0;
  assign le_sum  = {2'b00, mem_rsp_data[62:39], 7'b0} + {13'b0, entry_q, 4'b0};

  always_comb begin
    rd_go    = 1'b0;
    rd_addr  = '0;
    rd_next  = W_IDLE;
    fin      = 1'b0;
    fin_code = C_OK;
    fin_elem = '0;
    if (st == W_IDLE) begin
      if (start) begin
        if (ti.bad_reg) begin
          fin = 1'b1; fin_code = C_BADREG;
        end else if (ti.primary) begin
          fin = 1'b1; fin_elem = ctl_primary;
        end else if (ti.secondary) begin
          fin = 1'b1; fin_elem = ctl_secondary;
        end else if (ti.rsv_bad) begin
          fin = 1'b1; fin_code = C_TOKSPEC;
        end else begin
          rd_go = 1'b1; rd_addr = ADDR_W'(des_raw) + DES_OFS; rd_next = W_DES;
        end
      end
    end else if (mem_rsp_valid) begin
      if (mem_rsp_err) begin
        fin = 1'b1; fin_code = C_ADDR;
      end else begin
        case (st)
          W_DES: begin
            if ({6'b0, mem_rsp_data[38:32]} < entry_q[15:3]) begin
              fin = 1'b1; fin_code = C_ENTRY;
            end else if (|le_sum[32:31]) begin
              fin = 1'b1; fin_code = C_ADDR;
            end else begin
              rd_go = 1'b1; rd_addr = ADDR_W'(le_sum[31:0]); rd_next = W_LE0;
            end
          end
          W_LE0: begin
            if (mem_rsp_data[63]) begin
              fin = 1'b1; fin_code = C_ENTRY;
            end else if (mem_rsp_data[55:48] != seq_q) begin
              fin = 1'b1; fin_code = C_ENTSEQ;
            end else begin
              rd_go = 1'b1; rd_addr = le_addr_q + DW_STEP; rd_next = W_LE1;
            end
          end
          W_LE1: begin
            rd_go = 1'b1; rd_addr = ADDR_W'({mem_rsp_data[62:38], 6'b0}); rd_next = W_SE0;
          end
          W_SE0: begin
            if (mem_rsp_data[63]) begin
              fin = 1'b1; fin_code = C_SECVAL;
            end else begin
              rd_go = 1'b1; rd_addr = se_addr_q + DES_OFS; rd_next = W_SE2;
            end
          end
          W_SE2, W_AUTH: begin
            if (st == W_SE2 && mem_rsp_data[31:0] != se_sn_q) begin
              fin = 1'b1; fin_code = C_SECSEQ;
            end else if (st == W_SE2 && pv_q && eax_q != aix_q) begin
              if (over_len) begin
                fin = 1'b1; fin_code = C_AUTH;
              end else begin
                rd_go = 1'b1; rd_addr = auth_dw; rd_next = W_AUTH;
              end
            end else if (st == W_AUTH && !granted) begin
              fin = 1'b1; fin_code = C_AUTH;
            end else if (fo_q && wr_q) begin
              fin = 1'b1; fin_code = C_PROT;
            end else begin
              rd_go = 1'b1; rd_addr = se_addr_q + DW_STEP; rd_next = W_SE1;
            end
          end
          W_SE1: begin
            fin = 1'b1; fin_elem = mem_rsp_data;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= W_IDLE; req_q <= 1'b0; addr_q <= '0; done_q <= 1'b0;
      elem_q <= '0; code_q <= C_OK; seq_q <= '0; entry_q <= '0;
      wr_q <= 1'b0; fo_q <= 1'b0; pv_q <= 1'b0; eax_q <= '0; aix_q <= '0;
      le_addr_q <= '0; se_addr_q <= '0; se_sn_q <= '0; ato_q <= '0; atl_q <= '0;
    end else begin
      req_q  <= rd_go;
      done_q <= fin;
      if (rd_go) begin
        addr_q <= rd_addr;
        st     <= rd_next;
      end
      if (fin) begin
        st     <= W_IDLE;
        code_q <= fin_code;
        elem_q <= fin_elem;
      end
      if (st == W_IDLE && start) begin
        seq_q   <= ti.seq;
        entry_q <= ti.entry;
        wr_q    <= wr;
        eax_q   <= ctl_auth_idx[31:16];
      end
      if (mem_rsp_valid && !mem_rsp_err) begin
        case (st)
          W_DES: le_addr_q <= ADDR_W'(le_sum[31:0]);
          W_LE0: begin
            fo_q  <= mem_rsp_data[57];
            pv_q  <= mem_rsp_data[56];
            aix_q <= mem_rsp_data[47:32];
          end
          W_LE1: begin
            se_addr_q <= ADDR_W'({mem_rsp_data[62:38], 6'b0});
            se_sn_q   <= mem_rsp_data[31:0];
          end
          W_SE0: begin
            ato_q <= mem_rsp_data[62:34];
            atl_q <= mem_rsp_data[15:4];
          end
          default: ;
        endcase
      end
    end
  end

  assign mem_req  = req_q;
  assign mem_addr = addr_q;
  assign done     = done_q;
  assign elem     = elem_q;
  assign exc_code = code_q;

  logic pend_q;
  always_ff @(posedge clk) begin
    if (rst)                pend_q <= 1'b0;
    else if (mem_req)       pend_q <= 1'b1;
    else if (mem_rsp_valid) pend_q <= 1'b0;
  end

  // R13
  one_req_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !pend_q);

  // R13
  align_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[2:0] == 3'b000));

  // R5
  des_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && st == W_DES) |-> (mem_addr[5:0] == 6'h10 && !mem_addr[31]));

  // R1
  fast_chk: assert property (@(posedge clk) disable iff (rst)
    (st == W_IDLE && start && !ti.bad_reg && ti.primary)
      |=> (done && exc_code == C_OK && elem == $past(ctl_primary) && !mem_req));

  // R4
  badreg_chk: assert property (@(posedge clk) disable iff (rst)
    (st == W_IDLE && start && ti.bad_reg) |=> (done && exc_code == C_BADREG && !mem_req));

  // R13
  err_chk: assert property (@(posedge clk) disable iff (rst)
    (st != W_IDLE && mem_rsp_valid && mem_rsp_err) |=> (done && exc_code == C_ADDR));

  // R14
  elem_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (done && exc_code != C_OK) |-> (elem == '0));
endmodule

// File: tb/sim_aspace_token_xlate.sv
`timescale 1ns/1ps
module sim_aspace_token_xlate;
  localparam logic [63:0] CR1_C  = 64'hA1A1_0000_0000_1001;
  localparam logic [63:0] CR7_C  = 64'hB7B7_0000_0000_7007;
  localparam logic [63:0] ELEM_C = 64'h1122_3344_5566_7788;

  typedef struct packed {
    logic [4:0]  ar;
    logic [31:0] tok;
    logic        wr;
    logic [15:0] eax;
    logic        le_i, le_fo, le_p, le_snb, se_i, se_snb;
    logic [11:0] atl;
    logic [7:0]  auth;
    logic [1:0]  err;
    logic [1:0]  lat;
    logic [7:0]  exp;
    logic [3:0]  reads;
    logic [1:0]  src;
    logic [3:0]  tag;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{5'd0, 32'h005A0003, 1'b0, 16'h0012, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 12'd4, 8'h00, 2'd0, 2'd1, 8'h00, 4'd0, 2'd1, 4'd1},  // R1
    '{5'd3, 32'h00000000, 1'b0, 16'h0012, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 12'd4, 8'h00, 2'd0, 2'd1, 8'h00, 4'd0, 2'd1, 4'd1},  // R1
    '{5'd5, 32'h00000001, 1'b0, 16'h0012, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 12'd4, 8'h00, 2'd0, 2'd1, 8'h00, 4'd0, 2'd2, 4'd2},  // R2
    '{5'd2, 32'h80000003, 1'b0, 16'h0012, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 12'd4, 8'h00, 2'd0, 2'd1, 8'h28, 4'd0, 2'd3, 4'd3},  // R3
    '{5'd2, 32'h02000001, 1'b0, 16'h0012, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 12'd4, 8'h00, 2'd0, 2'd1, 8'h28, 4'd0, 2'd3, 4'd3},  // R3
    '{5'd16,32'h00000000, 1'b0, 16'h0012, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 12'd4, 8'h00, 2'd0, 2'd1, 8'hFF, 4'd0, 2'd3, 4'd4},  // R4
    '{5'd31,32'h00000001, 1'b0, 16'h0012, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 12'd4, 8'h00, 2'd0, 2'd1, 8'hFF, 4'd0, 2'd3, 4'd4},  // R4
    '{5'd4, 32'h005A0003, 1'b0, 16'h0012, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 12'd4, 8'h00, 2'd0, 2'd1, 8'h00, 4'd6, 2'd0, 4'd5},  // R5
    '{5'd4, 32'h005A0003, 1'b1, 16'h0012, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 12'd4, 8'h00, 2'd0, 2'd3, 8'h00, 4'd6, 2'd0, 4'd14}, // R14
    '{5'd4, 32'h005A0018, 1'b0, 16'h0012, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 12'd4, 8'h00, 2'd0, 2'd1, 8'h29, 4'd1, 2'd3, 4'd6},  // R6
    '{5'd4, 32'h005A0017, 1'b0, 16'h0012, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 12'd4, 8'h00, 2'd0, 2'd2, 8'h00, 4'd6, 2'd0, 4'd6},  // R6
    '{5'd6, 32'h015A0008, 1'b0, 16'h0012, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 12'd4, 8'h00, 2'd0, 2'd1, 8'h05, 4'd1, 2'd3, 4'd7},  // R7
    '{5'd6, 32'h015A0007, 1'b0, 16'h0012, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 12'd4, 8'h00, 2'd0, 2'd1, 8'h00, 4'd6, 2'd0, 4'd7},  // R7
    '{5'd4, 32'h005A0003, 1'b0, 16'h0012, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 12'd4, 8'h00, 2'd0, 2'd1, 8'h29, 4'd2, 2'd3, 4'd8},  // R8
    '{5'd4, 32'h005A0003, 1'b0, 16'h0012, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 12'd4, 8'h00, 2'd0, 2'd1, 8'h2A, 4'd2, 2'd3, 4'd8},  // R8
    '{5'd4, 32'h005A0003, 1'b0, 16'h0012, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 12'd4, 8'h00, 2'd0, 2'd1, 8'h2B, 4'd4, 2'd3, 4'd9},  // R9
    '{5'd4, 32'h005A0003, 1'b0, 16'h0012, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 12'd4, 8'h00, 2'd0, 2'd1, 8'h2C, 4'd5, 2'd3, 4'd9},  // R9
    '{5'd4, 32'h005A0003, 1'b0, 16'h0021, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 12'd1, 8'h10, 2'd0, 2'd1, 8'h2D, 4'd5, 2'd3, 4'd10}, // R10
    '{5'd4, 32'h005A0003, 1'b0, 16'h0021, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 12'd2, 8'h10, 2'd0, 2'd1, 8'h00, 4'd7, 2'd0, 4'd10}, // R10
    '{5'd4, 32'h005A0003, 1'b0, 16'h0021, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 12'd4, 8'h10, 2'd0, 2'd2, 8'h00, 4'd7, 2'd0, 4'd11}, // R11
    '{5'd4, 32'h005A0003, 1'b0, 16'h0022, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 12'd4, 8'h10, 2'd0, 2'd1, 8'h2D, 4'd6, 2'd3, 4'd11}, // R11
    '{5'd4, 32'h005A0003, 1'b0, 16'h0012, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 12'd4, 8'h00, 2'd0, 2'd1, 8'h00, 4'd6, 2'd0, 4'd11}, // R11
    '{5'd4, 32'h005A0003, 1'b1, 16'h0012, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 12'd4, 8'h00, 2'd0, 2'd1, 8'h04, 4'd5, 2'd3, 4'd12}, // R12
    '{5'd4, 32'h005A0003, 1'b0, 16'h0012, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 12'd4, 8'h00, 2'd0, 2'd1, 8'h00, 4'd6, 2'd0, 4'd12}, // R12
    '{5'd4, 32'h005A0003, 1'b0, 16'h0012, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 12'd4, 8'h00, 2'd1, 2'd2, 8'h05, 4'd2, 2'd3, 4'd13}, // R13
    '{5'd4, 32'h005A0003, 1'b0, 16'h0012, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 12'd4, 8'h00, 2'd2, 2'd1, 8'h05, 4'd6, 2'd3, 4'd13}  // R13
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [4:0]  ar_num = '0;
  logic [31:0] token = '0;
  logic        wr = 1'b0;
  logic [63:0] cr8 = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        rsp_v = 1'b0, rsp_e = 1'b0;
  logic [63:0] rsp_d = '0;
  logic        done;
  logic [63:0] elem;
  logic [7:0]  exc_code;

  logic [63:0] mem [logic [31:0]];
  logic [31:0] err_addr = '0;
  logic        err_en = 1'b0;
  int          lat = 1;
  int          nreads = 0;
  int          checks = 0;
  int          errors = 0;

  always #10 clk = ~clk;

  aspace_token_xlate u0 (
    .clk(clk), .rst(rst), .start(start), .ar_num(ar_num), .token(token), .wr(wr),
    .ctl_primary(CR1_C), .ctl_secondary(CR7_C),
    .ctl_list_base(64'hFFFF_FFFF_8000_103F), .ctl_priv_base(64'h0000_0000_0000_3000),
    .ctl_auth_idx(cr8), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rsp_valid(rsp_v), .mem_rsp_err(rsp_e), .mem_rsp_data(rsp_d),
    .done(done), .elem(elem), .exc_code(exc_code)
  );

  initial begin : responder
    forever begin
      @(negedge clk);
      rsp_v = 1'b0;
      rsp_e = 1'b0;
      if (mem_req) begin
        logic [31:0] a;
        a = mem_addr;
        nreads++;
        repeat (lat) @(negedge clk);
        rsp_v = 1'b1;
        rsp_e = err_en && (a == err_addr);
        rsp_d = mem.exists(a) ? mem[a] : 64'h0;
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic build(input vec_t v);
    logic [23:0] alo;
    logic [31:0] le;
    mem.delete();
    mem[32'h1010] = {1'b0, 24'h000040, 7'd2, 32'h0};
    mem[32'h3010] = {1'b0, 24'hFFFFFF, 7'h7F, 32'h0};
    alo = v.tok[24] ? 24'hFFFFFF : 24'h000040;
    le  = {1'b0, alo, 7'b0} + {12'b0, v.tok[15:0], 4'b0};
    mem[le] = {v.le_i, 5'b0, v.le_fo, v.le_p,
               (v.le_snb ? (v.tok[23:16] ^ 8'h01) : v.tok[23:16]), 16'h0012, 32'h0};
    mem[le + 32'd8]  = {1'b0, 25'h100, 6'b0, 32'hDEAD_BEEF};
    mem[32'h4000]    = {v.se_i, 29'h1400, 1'b0, 1'b0, 16'h0, v.atl, 4'b0};
    mem[32'h4008]    = ELEM_C;
    mem[32'h4010]    = {32'h0, (v.se_snb ? 32'hDEAD_BEEE : 32'hDEAD_BEEF)};
    mem[32'h5008]    = {v.auth, 56'h0};
    err_en   = (v.err != 2'd0);
    err_addr = (v.err == 2'd1) ? le : 32'h4008;
  endtask

  task automatic run_vec(input vec_t v);
    string rq;
    logic [63:0] exp_elem;
    int t;
    rq = $sformatf("R%0d", v.tag);
    build(v);
    @(negedge clk);
    ar_num = v.ar; token = v.tok; wr = v.wr;
    cr8 = {32'h0, v.eax, 16'hBEEF};
    lat = int'(v.lat);
    nreads = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (!done && t < 300) begin
      @(negedge clk);
      t++;
    end
    case (v.src)
      2'd0: exp_elem = ELEM_C;
      2'd1: exp_elem = CR1_C;
      2'd2: exp_elem = CR7_C;
      default: exp_elem = 64'h0;
    endcase
    chk(done == 1'b1, rq, 64'(done), 64'd1);
    chk(exc_code == v.exp, rq, 64'(exc_code), 64'(v.exp));
    chk(elem == exp_elem, rq, elem, exp_elem);
    chk(nreads == int'(v.reads), rq, 64'(nreads), 64'(v.reads));
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [63:0] held_elem;
    logic [7:0]  held_code;
    repeat (3) @(negedge clk);
    // R14: outputs cleared by reset
    chk(done == 1'b0, "R14", 64'(done), 64'd0);
    chk(mem_req == 1'b0, "R13", 64'(mem_req), 64'd0);
    chk(elem == 64'h0, "R14", elem, 64'h0);
    chk(exc_code == 8'h00, "R14", 64'(exc_code), 64'h0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R14: result held after the strobe until the next request
    run_vec(VECS[7]);
    held_elem = elem;
    held_code = exc_code;
    repeat (6) @(negedge clk);
    chk(elem == held_elem && elem == ELEM_C, "R14", elem, ELEM_C);
    chk(exc_code == held_code, "R14", 64'(exc_code), 64'(held_code));
    chk(done == 1'b0, "R14", 64'(done), 64'd0);

    // R3: register zero wins over reserved token bits
    run_vec('{5'd0, 32'hFE000005, 1'b0, 16'h0012, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,
              12'd4, 8'h00, 2'd0, 2'd1, 8'h00, 4'd0, 2'd1, 4'd3});

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule